// File: doc/BRIEF.md
# Programmable Static Memory Write Sequencer

This block generates the external write cycle for an asynchronous static memory or a peripheral bus. It drives the address, active-low byte selects, write data, an active-low chip select and an active-low write strobe. A host hands over one write at a time through a request/acknowledge handshake. When the sequencer is idle it acknowledges the request in the same cycle and latches the address, data, byte enables and the timing configuration. It then runs a single cycle counter through the programmed cycle length, and each strobe is low inside its own window of that count.

Each strobe has its own setup and pulse lengths, counted in clock cycles. Its hold is whatever remains of the total cycle length. A control-select bit chooses which strobe's rising edge ends the transfer. The other strobe is kept low at least until that edge, so the controlling strobe never rises after its partner. A cycle length that is too short for either window is stretched to fit. When the cycle finishes, a one-cycle done pulse is issued, and a new request can be taken in that same cycle.

Top module: `smc_write_seq`

## Requirements
- R1: While reset is asserted and after it is released, chip select and write strobe are high (1), busy and done are 0, and the address, data and byte-select outputs are 0.
- R2: ack_o equals req_i AND NOT busy_o in every cycle. A request made while busy is not accepted, and it does not disturb the running cycle.
- R3: The count k is 0 in the cycle after acceptance and then rises by one per cycle. The write strobe is low exactly while busy and nwe_setup <= k < stop_we.
- R4: The chip select is low exactly while busy and ncs_setup <= k < stop_cs.
- R5: With ctl_nwe_i = 1 (write-strobe controlled), stop_we = nwe_setup+nwe_pulse and stop_cs = max(ncs_setup+ncs_pulse, stop_we). With ctl_nwe_i = 0 (chip-select controlled), stop_cs = ncs_setup+ncs_pulse and stop_we = max(nwe_setup+nwe_pulse, stop_cs). The controlling strobe therefore never rises after the other.
- R6: Busy stays high for L = max(cycle_len, nwe_setup+nwe_pulse, ncs_setup+ncs_pulse, 1) cycles. Done is high for exactly the one cycle after busy falls.
- R7: The address, data and byte selects take the request values at acceptance (the byte-select output is the bitwise inverse of the byte enables). They do not change until the next acceptance.
- R8: The timing inputs and the control-select bit are sampled only at acceptance. Changing them during a cycle has no effect on that cycle.
- R9: A request that is pending while done is high is accepted in that cycle, and the next cycle starts at k = 0 on the following clock.
- R10: A pulse length of 0 leaves that strobe high for the whole transfer (unless R5 extends it over the other strobe's window).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Write request |
| ack_o | output | 1 | Request accepted this cycle |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data |
| be_i | input | BE_W | Byte enables, active high |
| we_setup_i | input | CNT_W | Write-strobe setup cycles |
| we_pulse_i | input | CNT_W | Write-strobe pulse cycles |
| cs_setup_i | input | CNT_W | Chip-select setup cycles |
| cs_pulse_i | input | CNT_W | Chip-select pulse cycles |
| cyc_len_i | input | CNT_W | Total cycle length |
| ctl_nwe_i | input | 1 | 1: write strobe ends the transfer, 0: chip select does |
| busy_o | output | 1 | Write cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | ADDR_W | External address |
| mem_bs_n_o | output | BE_W | External byte selects, active low |
| mem_data_o | output | DATA_W | External write data |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |

## Verification
The end of one cycle and the acceptance of the next can fall on the same clock. In that cycle done is high, busy is low, and the pending request is acknowledged. The bench provokes this by keeping a second request high through the whole of the first transfer. The second request carries different data and timing, so that an early acceptance or a late one is exposed. A behavioural model predicts the done pulse, the acknowledge and the first strobe values of the new cycle, and every output is compared with that model on every clock.

// File: rtl/smc_wr_pkg.sv
package smc_wr_pkg;

   typedef enum logic {
      CTL_BY_CS = 1'b0,
      CTL_BY_WE = 1'b1
   } ctl_sel_e;

   localparam int STROBE_N = 2;
   localparam int IDX_WE   = 0;
   localparam int IDX_CS   = 1;

endpackage

// File: rtl/smc_wr_timing.sv
module smc_wr_timing
   import smc_wr_pkg::*;
#(
   parameter int CNT_W = 8,
   localparam int EW   = CNT_W + 1
) (
   input  logic [CNT_W-1:0] we_setup,
   input  logic [CNT_W-1:0] we_pulse,
   input  logic [CNT_W-1:0] cs_setup,
   input  logic [CNT_W-1:0] cs_pulse,
   input  logic [CNT_W-1:0] cyc_len,
   input  ctl_sel_e         ctl,
   output logic [EW-1:0]    we_start,
   output logic [EW-1:0]    we_stop,
   output logic [EW-1:0]    cs_start,
   output logic [EW-1:0]    cs_stop,
   output logic [EW-1:0]    len
);

   logic [EW-1:0] we_end, cs_end, late_end, base_len;

   always_comb begin
      we_end   = EW'(we_setup) + EW'(we_pulse);
      cs_end   = EW'(cs_setup) + EW'(cs_pulse);
      late_end = (we_end > cs_end) ? we_end : cs_end;
      we_start = EW'(we_setup);
      cs_start = EW'(cs_setup);
      if (ctl == CTL_BY_WE) begin
         we_stop = we_end;
         cs_stop = late_end;
      end else begin
         we_stop = late_end;
         cs_stop = cs_end;
      end
      base_len = (EW'(cyc_len) > late_end) ? EW'(cyc_len) : late_end;
      len      = (base_len == '0) ? EW'(1) : base_len;
   end

endmodule

// File: rtl/smc_wr_strobe.sv
module smc_wr_strobe #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] start,
   input  logic [CW-1:0] stop,
   output logic          strobe_n
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_n <= 1'b1;
      else        strobe_n <= !(run && (cnt >= start) && (cnt < stop));
   end

endmodule

// File: rtl/smc_write_seq.sv
module smc_write_seq
   import smc_wr_pkg::*;
#(
   parameter int ADDR_W = 26,
   parameter int DATA_W = 32,
   parameter int BE_W   = 4,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   output logic              ack_o,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic [CNT_W-1:0]  we_setup_i,
   input  logic [CNT_W-1:0]  we_pulse_i,
   input  logic [CNT_W-1:0]  cs_setup_i,
   input  logic [CNT_W-1:0]  cs_pulse_i,
   input  logic [CNT_W-1:0]  cyc_len_i,
   input  logic              ctl_nwe_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [BE_W-1:0]   mem_bs_n_o,
   output logic [DATA_W-1:0] mem_data_o,
   output logic              mem_cs_n_o,
   output logic              mem_we_n_o
);

   localparam int EW = CNT_W + 1;

   if (CNT_W < 2)           begin : g_bad_cnt  $error("CNT_W must be at least 2");      end
   if (ADDR_W < 1)          begin : g_bad_addr $error("ADDR_W must be positive");       end
   if (DATA_W % BE_W != 0)  begin : g_bad_be   $error("DATA_W must split into BE_W lanes"); end

   logic              busy_q, done_q, accept, last, run_nxt;
   logic [EW-1:0]     cnt_q, cnt_nxt;
   logic [CNT_W-1:0]  we_s_q, we_p_q, cs_s_q, cs_p_q, len_q;
   ctl_sel_e          ctl_q, ctl_sel;
   logic [CNT_W-1:0]  we_s_sel, we_p_sel, cs_s_sel, cs_p_sel, len_sel;
   logic [EW-1:0]     t_start [STROBE_N];
   logic [EW-1:0]     t_stop  [STROBE_N];
   logic [EW-1:0]     t_len;
   logic [STROBE_N-1:0] strb_n;

   assign accept = req_i && !busy_q;
   assign ack_o  = accept;

   // on acceptance the fresh configuration drives the first count value
   always_comb begin
      if (accept) begin
         we_s_sel = we_setup_i; we_p_sel = we_pulse_i;
         cs_s_sel = cs_setup_i; cs_p_sel = cs_pulse_i;
         len_sel  = cyc_len_i;
         ctl_sel  = ctl_sel_e'(ctl_nwe_i);
      end else begin
         we_s_sel = we_s_q; we_p_sel = we_p_q;
         cs_s_sel = cs_s_q; cs_p_sel = cs_p_q;
         len_sel  = len_q;
         ctl_sel  = ctl_q;
      end
   end

   smc_wr_timing #(.CNT_W(CNT_W)) u_timing (
      .we_setup (we_s_sel),
      .we_pulse (we_p_sel),
      .cs_setup (cs_s_sel),
      .cs_pulse (cs_p_sel),
      .cyc_len  (len_sel),
      .ctl      (ctl_sel),
      .we_start (t_start[IDX_WE]),
      .we_stop  (t_stop[IDX_WE]),
      .cs_start (t_start[IDX_CS]),
      .cs_stop  (t_stop[IDX_CS]),
      .len      (t_len)
   );

   assign last    = busy_q && (cnt_q == t_len - EW'(1));
   assign run_nxt = accept || (busy_q && !last);
   assign cnt_nxt = accept ? '0 : cnt_q + EW'(1);

   for (genvar i = 0; i < STROBE_N; i++) begin : g_strobe
      smc_wr_strobe #(.CW(EW)) u_strobe (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (run_nxt),
         .cnt      (cnt_nxt),
         .start    (t_start[i]),
         .stop     (t_stop[i]),
         .strobe_n (strb_n[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         cnt_q      <= '0;
         we_s_q     <= '0;
         we_p_q     <= '0;
         cs_s_q     <= '0;
         cs_p_q     <= '0;
         len_q      <= '0;
         ctl_q      <= CTL_BY_CS;
         mem_addr_o <= '0;
         mem_data_o <= '0;
         mem_bs_n_o <= '0;
      end else begin
         busy_q <= run_nxt;
         done_q <= last;
         if (run_nxt) cnt_q <= cnt_nxt;
         if (accept) begin
            we_s_q     <= we_setup_i;
            we_p_q     <= we_pulse_i;
            cs_s_q     <= cs_setup_i;
            cs_p_q     <= cs_pulse_i;
            len_q      <= cyc_len_i;
            ctl_q      <= ctl_sel_e'(ctl_nwe_i);
            mem_addr_o <= addr_i;
            mem_data_o <= data_i;
            mem_bs_n_o <= ~be_i;
         end
      end
   end

   assign busy_o     = busy_q;
   assign done_o     = done_q;
   assign mem_we_n_o = strb_n[IDX_WE];
   assign mem_cs_n_o = strb_n[IDX_CS];

endmodule

// File: rtl/smc_wr_chk.sv
module smc_wr_chk #(
   parameter int ADDR_W = 26,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_i,
   input logic              ack_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              ctl_lat,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [DATA_W-1:0] mem_data_o,
   input logic              mem_cs_n_o,
   input logic              mem_we_n_o
);

   // R2
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (req_i && !busy_o));

   // R3
   we_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> mem_we_n_o);

   // R4
   cs_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> mem_cs_n_o);

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ($stable(mem_addr_o) && $stable(mem_data_o)));

   // R5
   we_ctl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && ctl_lat && $rose(mem_cs_n_o)) |-> mem_we_n_o);

   // R5
   cs_ctl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !ctl_lat && $rose(mem_we_n_o)) |-> mem_cs_n_o);

endmodule

bind smc_write_seq smc_wr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_i      (req_i),
   .ack_o      (ack_o),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .ctl_lat    (ctl_q),
   .mem_addr_o (mem_addr_o),
   .mem_data_o (mem_data_o),
   .mem_cs_n_o (mem_cs_n_o),
   .mem_we_n_o (mem_we_n_o)
);

// File: tb/tb_smc_write_seq.sv
module tb_smc_write_seq;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 26;
   localparam int DATA_W = 32;
   localparam int BE_W   = 4;
   localparam int CNT_W  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic [DATA_W-1:0] data_i = '0;
   logic [BE_W-1:0]   be_i = '0;
   logic [CNT_W-1:0]  we_setup_i = '0, we_pulse_i = '0, cs_setup_i = '0, cs_pulse_i = '0, cyc_len_i = '0;
   logic ctl_nwe_i = 1'b0;
   logic ack_o, busy_o, done_o, mem_cs_n_o, mem_we_n_o;
   logic [ADDR_W-1:0] mem_addr_o;
   logic [BE_W-1:0]   mem_bs_n_o;
   logic [DATA_W-1:0] mem_data_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   smc_write_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_o(ack_o),
      .addr_i(addr_i), .data_i(data_i), .be_i(be_i),
      .we_setup_i(we_setup_i), .we_pulse_i(we_pulse_i),
      .cs_setup_i(cs_setup_i), .cs_pulse_i(cs_pulse_i),
      .cyc_len_i(cyc_len_i), .ctl_nwe_i(ctl_nwe_i),
      .busy_o(busy_o), .done_o(done_o),
      .mem_addr_o(mem_addr_o), .mem_bs_n_o(mem_bs_n_o), .mem_data_o(mem_data_o),
      .mem_cs_n_o(mem_cs_n_o), .mem_we_n_o(mem_we_n_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   int m_busy = 0, m_done = 0, m_k = 0, m_len = 1;
   int m_ws = 0, m_wstop = 0, m_cs = 0, m_cstop = 0;
   logic [ADDR_W-1:0] m_addr = '0;
   logic [DATA_W-1:0] m_data = '0;
   logic [BE_W-1:0]   m_bs_n = '0;

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_k = 0;
         m_addr = '0; m_data = '0; m_bs_n = '0;
      end else begin
         automatic bit acc = req_i && (m_busy == 0);
         if (m_busy != 0) begin
            if (m_k == m_len - 1) begin m_busy = 0; m_done = 1; end
            else begin m_k++; m_done = 0; end
         end else m_done = 0;
         if (acc) begin
            automatic int ew = int'(we_setup_i) + int'(we_pulse_i);
            automatic int ec = int'(cs_setup_i) + int'(cs_pulse_i);
            m_ws = int'(we_setup_i);
            m_cs = int'(cs_setup_i);
            if (ctl_nwe_i) begin m_wstop = ew; m_cstop = imax(ec, ew); end
            else           begin m_cstop = ec; m_wstop = imax(ew, ec); end
            m_len  = imax(imax(int'(cyc_len_i), imax(ew, ec)), 1);
            m_busy = 1; m_k = 0;
            m_addr = addr_i; m_data = data_i; m_bs_n = ~be_i;
         end
      end
   end

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0h expected %0h", rq, cycles, act, exp);
      end
   endtask

   // compare at a quarter period after the falling edge
   always @(negedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n) begin
         automatic bit we_low = (m_busy != 0) && (m_k >= m_ws) && (m_k < m_wstop);
         automatic bit cs_low = (m_busy != 0) && (m_k >= m_cs) && (m_k < m_cstop);
         chk("R2 ack", 64'(ack_o), 64'(req_i && (m_busy == 0)));
         chk("R3/R5/R10 we_n", 64'(mem_we_n_o), 64'(!we_low));
         chk("R4/R5/R10 cs_n", 64'(mem_cs_n_o), 64'(!cs_low));
         chk("R6/R9 busy", 64'(busy_o), 64'(m_busy != 0));
         chk("R6/R9 done", 64'(done_o), 64'(m_done != 0));
         chk("R7/R8 addr", 64'(mem_addr_o), 64'(m_addr));
         chk("R7/R8 data", 64'(mem_data_o), 64'(m_data));
         chk("R7 bs_n", 64'(mem_bs_n_o), 64'(m_bs_n));
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   // set up a request at a falling edge, keep it until accepted
   task automatic issue(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic [BE_W-1:0] b,
                        input int ws, input int wp, input int cs, input int cp, input int len, input bit ctl);
      @(negedge clk);
      req_i = 1'b1; addr_i = a; data_i = d; be_i = b;
      we_setup_i = CNT_W'(ws); we_pulse_i = CNT_W'(wp);
      cs_setup_i = CNT_W'(cs); cs_pulse_i = CNT_W'(cp);
      cyc_len_i = CNT_W'(len); ctl_nwe_i = ctl;
      while (busy_o) @(negedge clk);
      @(negedge clk);
      req_i = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy_o) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cs_n", 64'(mem_cs_n_o), 64'd1);
      chk("R1 we_n", 64'(mem_we_n_o), 64'd1);
      chk("R1 busy", 64'(busy_o), 64'd0);
      chk("R1 done", 64'(done_o), 64'd0);
      chk("R1 addr", 64'(mem_addr_o), 64'd0);
      chk("R1 data", 64'(mem_data_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release cs_n", 64'(mem_cs_n_o), 64'd1);

      // R3 R4 R5 write-strobe controlled with holds
      issue(26'h155AAAA, 32'hDEADBEEF, 4'b0101, 2, 3, 1, 3, 8, 1'b1);
      wait_idle();
      // R5 chip-select controlled, partner extended
      issue(26'h0000123, 32'h12345678, 4'b1111, 1, 2, 2, 4, 9, 1'b0);
      // R8 change configuration mid-cycle
      @(negedge clk);
      we_setup_i = 8'd7; cs_pulse_i = 8'd1; cyc_len_i = 8'd2; ctl_nwe_i = 1'b1; addr_i = 26'h3FFFFFF;
      wait_idle();
      // R6 stretch: windows longer than cycle length, zero hold
      issue(26'h2AAAAAA, 32'h0F0F0F0F, 4'b1000, 3, 4, 0, 5, 2, 1'b1);
      wait_idle();
      // R10 zero pulses and zero length
      issue(26'h0000001, 32'h00000001, 4'b0001, 0, 0, 0, 0, 0, 1'b1);
      wait_idle();
      issue(26'h0000002, 32'h00000002, 4'b0010, 0, 0, 1, 2, 3, 1'b0);
      wait_idle();
      // R2 R9 back-to-back: second request pending through first transfer
      issue(26'h1111111, 32'hAAAA5555, 4'b0011, 1, 1, 0, 3, 6, 1'b0);
      issue(26'h2222222, 32'h5555AAAA, 4'b1100, 0, 2, 1, 1, 4, 1'b1);
      issue(26'h3333333, 32'hCAFEF00D, 4'b0110, 2, 1, 0, 4, 1, 1'b0);
      wait_idle();
      finish_run();
   end

endmodule